// File: doc/BRIEF.md
# Multicycle Indexed Arithmetic Coprocessor

This block sits beside a processor core and runs one of several arithmetic operations on two 32-bit operands. The caller presents the operands and an 8-bit operation selector, then raises `launch` for one cycle. The block then runs for a number of cycles that depends on the selected operation. It raises `complete` for one enabled cycle, with the answer on `outcome` in that same cycle. The caller keeps both operands steady from the launch cycle through the completion cycle, so the block never stores a copy of them.

Three operations are built in. The first is a shift-add multiplier that returns the low half of the product. The second is a restoring divider that returns the unsigned quotient. The third is a population count that finishes in a fixed two cycles. Any other selector value completes at once with a zero answer. The clock qualifier `cke` freezes every register while it is low, so latency counts only enabled edges. Reset is asynchronous and active low, and its release is expected to be synchronous to `clk`.

Top module: `mcop_unit`

## Requirements
- R1: While `rst_n` is low, `outcome` is 0 and `complete` is 0, and the block is idle.
- R2: With `op_sel` = 0, the block returns the low 32 bits of `op_a * op_b`. `complete` is high after the 33rd enabled rising edge, counting the edge that samples `launch` as the 1st.
- R3: With `op_sel` = 1, the block returns the unsigned quotient `op_a / op_b`, with the same 33-edge latency as R2.
- R4: With `op_sel` = 1 and `op_b` = 0, the block returns 0xFFFFFFFF, with the same 33-edge latency.
- R5: With `op_sel` = 2, the block returns the number of set bits in `op_a`, and `complete` is high after the 2nd enabled edge.
- R6: Any `op_sel` value from 3 to 255 completes after the 1st enabled edge with `outcome` = 0.
- R7: `complete` is high for exactly one enabled cycle. `outcome` keeps the last answer until the next completion.
- R8: A `launch` pulse that arrives while an operation is running is ignored. The running operation finishes with its own answer and latency.
- R9: While `cke` is low, every register holds its value. Edges with `cke` low do not count toward latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to clk |
| cke | input | 1 | Clock qualifier; when low, all state holds |
| launch | input | 1 | One-cycle pulse that starts an operation when the block is idle |
| op_sel | input | 8 | Operation selector: 0 multiply, 1 divide, 2 population count, others return zero |
| op_a | input | 32 | First operand (multiplicand, dividend, or population count source); held stable by the caller |
| op_b | input | 32 | Second operand (multiplier or divisor); held stable by the caller |
| outcome | output | 32 | Answer; valid while complete is high and held afterwards |
| complete | output | 1 | One-enabled-cycle completion pulse |

## Verification
The bench checks latency as a count of enabled edges, not wall cycles. A design that counted stalled edges, or that was off by one in its iteration counter, would finish early or late and be caught. Division by zero is exercised: a divider that special-cased it wrongly, or cut its iteration short, would return a value other than all ones or the wrong latency. A launch pulse with an unused selector is injected in the middle of a multiply. A design that accepted it would return zero early instead of the product. Operands with the top bits set show up any truncation in the restoring compare or the product wrap, and the three population count values cover 0, a mixed pattern and all ones.

// File: rtl/mcop_pkg.sv
package mcop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PCNT = 2'd2
  } mcop_state_e;

  localparam int unsigned SEL_MUL  = 0;
  localparam int unsigned SEL_DIV  = 1;
  localparam int unsigned SEL_PCNT = 2;
endpackage

// File: rtl/mcop_mul_step.sv
module mcop_mul_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mcand,
  input  logic         mbit,
  output logic [W-1:0] acc_nx,
  output logic [W-1:0] mcand_nx
);
  always_comb begin
    acc_nx   = mbit ? (acc + mcand) : acc;
    mcand_nx = {mcand[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mcop_div_step.sv
module mcop_div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic         nbit,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] rem_nx,
  output logic [W-1:0] quo_nx
);
  logic [W:0] shifted;
  logic [W:0] dvs_ext;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {rem, nbit};
    dvs_ext = {1'b0, divisor};
    diff    = shifted - dvs_ext;
    fits    = (shifted >= dvs_ext);
    rem_nx  = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_nx  = {quo[W-2:0], fits};
  end
endmodule

// File: rtl/mcop_popcnt.sv
module mcop_popcnt #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + W'(vec[i]);
    end
  end
endmodule

// File: rtl/mcop_unit.sv
module mcop_unit
  import mcop_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             launch,
  input  logic [SEL_W-1:0] op_sel,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic [W-1:0]     outcome,
  output logic             complete
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mcop_state_e   st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          is_div_q, is_div_nx;
  logic [W-1:0]  acc_q, acc_nx;
  logic [W-1:0]  aux_q, aux_nx;
  logic [W-1:0]  res_q, res_nx;
  logic          done_q, done_nx;

  logic [W-1:0]  mul_acc, mul_aux;
  logic [W-1:0]  div_rem, div_quo;
  logic [W-1:0]  ones;

  // One shift-add iteration: multiplier bit chosen from the held operand.
  mcop_mul_step #(.W(W)) u_mul (
    .acc      (acc_q),
    .mcand    (aux_q),
    .mbit     (op_b[cnt_q]),
    .acc_nx   (mul_acc),
    .mcand_nx (mul_aux)
  );

  // One restoring iteration: dividend bits fed in MSB first.
  mcop_div_step #(.W(W)) u_div (
    .rem     (aux_q),
    .quo     (acc_q),
    .nbit    (op_a[LAST - cnt_q]),
    .divisor (op_b),
    .rem_nx  (div_rem),
    .quo_nx  (div_quo)
  );

  mcop_popcnt #(.W(W)) u_pcnt (
    .vec  (op_a),
    .ones (ones)
  );

  always_comb begin
    st_nx     = st_q;
    cnt_nx    = cnt_q;
    is_div_nx = is_div_q;
    acc_nx    = acc_q;
    aux_nx    = aux_q;
    res_nx    = res_q;
    done_nx   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          if (op_sel == SEL_W'(SEL_MUL)) begin
            st_nx     = ST_RUN;
            cnt_nx    = '0;
            is_div_nx = 1'b0;
            acc_nx    = '0;
            aux_nx    = op_a;
          end else if (op_sel == SEL_W'(SEL_DIV)) begin
            st_nx     = ST_RUN;
            cnt_nx    = '0;
            is_div_nx = 1'b1;
            acc_nx    = '0;
            aux_nx    = '0;
          end else if (op_sel == SEL_W'(SEL_PCNT)) begin
            st_nx = ST_PCNT;
          end else begin
            res_nx  = '0;
            done_nx = 1'b1;
          end
        end
      end
      ST_RUN: begin
        cnt_nx = cnt_q + CW'(1);
        acc_nx = is_div_q ? div_quo : mul_acc;
        aux_nx = is_div_q ? div_rem : mul_aux;
        if (cnt_q == LAST) begin
          st_nx   = ST_IDLE;
          res_nx  = is_div_q ? div_quo : mul_acc;
          done_nx = 1'b1;
        end
      end
      ST_PCNT: begin
        st_nx   = ST_IDLE;
        res_nx  = ones;
        done_nx = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      is_div_q <= 1'b0;
      acc_q    <= '0;
      aux_q    <= '0;
      res_q    <= '0;
      done_q   <= 1'b0;
    end else if (cke) begin
      st_q     <= st_nx;
      cnt_q    <= cnt_nx;
      is_div_q <= is_div_nx;
      acc_q    <= acc_nx;
      aux_q    <= aux_nx;
      res_q    <= res_nx;
      done_q   <= done_nx;
    end
  end

  assign outcome  = res_q;
  assign complete = done_q;

  // R9: a disabled edge changes nothing
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(outcome) && $stable(complete) && $stable(st_q) && $stable(cnt_q)));

  // R2: a run completes only from its final iteration
  p_run_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cke && cnt_q != LAST) |=> (st_q == ST_RUN && !complete));

  // R8: launch during a run neither restarts nor stalls the counter
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cke && launch && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R3: restoring remainder stays below a nonzero divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && is_div_q && cke && cnt_q != LAST && op_b != '0) |=> (aux_q < op_b));

  // R5: population count finishes one edge after leaving idle
  p_pcnt_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PCNT && cke) |=> (complete && st_q == ST_IDLE && outcome <= W));

  // R6: unused selector completes at once with zero
  p_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cke && launch && op_sel > SEL_W'(SEL_PCNT)) |=> (complete && outcome == '0));

  // R7: completion lasts one enabled cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && cke && !launch) |=> !complete);
endmodule

// File: tb/mcop_unit_bench.sv
module mcop_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        launch = 1'b0;
  logic [7:0]  op_sel = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] outcome;
  logic        complete;

  typedef struct {
    logic [31:0] val;
    int          lat;
    int          mark;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   en_edges = 0;
  bit   prev_c = 1'b0;
  bit   ended = 1'b0;

  always #4 clk = ~clk;

  mcop_unit u_mcop_unit (
    .clk(clk), .rst_n(rst_n), .cke(cke), .launch(launch), .op_sel(op_sel),
    .op_a(op_a), .op_b(op_b), .outcome(outcome), .complete(complete)
  );

  always @(posedge clk) if (rst_n && cke) en_edges <= en_edges + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item on each rising completion.
  always @(negedge clk) begin
    if (rst_n && complete && !prev_c) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 unexpected completion", outcome, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(outcome == e.val, {e.tag, " value"}, outcome, e.val);
        chk((en_edges - e.mark) == e.lat, {e.tag, " latency"}, 32'(en_edges - e.mark), 32'(e.lat));
      end
    end
    prev_c = complete;
  end

  task automatic run_op(input logic [7:0] sel, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp, input int lat, input string tag,
                        input bit stall, input bit poke);
    exp_t e;
    int i;
    @(negedge clk); #1;
    op_sel = sel; op_a = a; op_b = b; launch = 1'b1; cke = 1'b1;
    e.val = exp; e.lat = lat; e.mark = en_edges; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk); #1;
    launch = 1'b0;
    i = 0;
    while (sb_q.size() != 0 && i < 400) begin
      if (poke && i == 5) begin launch = 1'b1; op_sel = 8'd3; end
      else if (poke && i == 6) begin launch = 1'b0; op_sel = sel; end
      cke = stall ? (i % 3 != 2) : 1'b1;
      @(negedge clk); #1;
      i++;
    end
    if (i >= 400) begin
      chk(1'b0, {tag, " timeout"}, 32'h0, exp);
      sb_q.delete();
    end
    cke = 1'b1;
    repeat (2) @(negedge clk);
    chk(complete == 1'b0, "R7 pulse ended", 32'(complete), 32'h0);
    chk(outcome == exp, "R7 outcome held", outcome, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outcome == 32'h0, "R1 reset outcome", outcome, 32'h0);
    chk(complete == 1'b0, "R1 reset complete", 32'(complete), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(complete == 1'b0, "R1 idle after reset", 32'(complete), 32'h0);

    run_op(8'd0, 32'd3, 32'd5, 32'd15, 33, "R2 mul small", 1'b0, 1'b0);
    run_op(8'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1, 33, "R2 mul wrap", 1'b0, 1'b0);
    run_op(8'd0, 32'h12345678, 32'h9ABCDEF0, 32'h12345678 * 32'h9ABCDEF0, 33, "R2 mul mixed", 1'b0, 1'b0);
    run_op(8'd1, 32'd100, 32'd7, 32'd14, 33, "R3 div", 1'b0, 1'b0);
    run_op(8'd1, 32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 33, "R3 div by one", 1'b0, 1'b0);
    run_op(8'd1, 32'd5, 32'd9, 32'd0, 33, "R3 div small", 1'b0, 1'b0);
    run_op(8'd1, 32'hF0000000, 32'h80000001, 32'hF0000000 / 32'h80000001, 33, "R3 div high", 1'b0, 1'b0);
    run_op(8'd1, 32'h1234, 32'd0, 32'hFFFFFFFF, 33, "R4 div zero", 1'b0, 1'b0);
    run_op(8'd2, 32'hF0F00001, 32'd0, 32'($countones(32'hF0F00001)), 2, "R5 pcnt mixed", 1'b0, 1'b0);
    run_op(8'd2, 32'h0, 32'd0, 32'd0, 2, "R5 pcnt zero", 1'b0, 1'b0);
    run_op(8'd2, 32'hFFFFFFFF, 32'd0, 32'd32, 2, "R5 pcnt full", 1'b0, 1'b0);
    run_op(8'd3, 32'hDEADBEEF, 32'd1, 32'd0, 1, "R6 sel 3", 1'b0, 1'b0);
    run_op(8'd255, 32'hDEADBEEF, 32'd1, 32'd0, 1, "R6 sel 255", 1'b0, 1'b0);
    run_op(8'd0, 32'd1000, 32'd77, 32'd77000, 33, "R8 busy launch mul", 1'b0, 1'b1);
    run_op(8'd1, 32'd999999, 32'd123, 32'd999999 / 32'd123, 33, "R9 stalled div", 1'b1, 1'b0);
    run_op(8'd0, 32'hABCD, 32'h1357, 32'hABCD * 32'h1357, 33, "R9 stalled mul", 1'b1, 1'b0);
    run_op(8'd2, 32'h00FF00FF, 32'd0, 32'd16, 2, "R9 stalled pcnt", 1'b1, 1'b0);

    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule